// File: doc/BRIEF.md
# Key-Gated Programming Unlock

This block is the target-side control and status register space of a debug port. It receives instructions that an upstream decoder has already parsed and split into byte payloads. A store writes one byte into a control/status register. A load reads one back. A key instruction opens a window for eight key bytes. The block drives three things: the read data, an internal reset request, and a status bit that grants the debug port access to the nonvolatile-memory controller.

Access is granted in two steps. The host first writes the hold signature 0x59 into the reset register, which keeps the device core in reset. It then streams the 64-bit unlock key, least-significant byte first. When the eighth byte completes a key equal to 0x1289AB45CDD888FF while the reset hold is active, the NVM-enable bit is set. The host polls the status register until it sees that bit. Writing any other value to the reset register releases the core and withdraws NVM access.

Top module: `key_unlock_csr`

## Requirements
- R1: After reset, core_reset and nvm_en are 0, and loads from addresses 0, 1 and 2 return 0x00.
- R2: A store of 0x59 to address 1 (reset register) sets core_reset on the cycle after the store. A later load of address 1 then returns 0x01.
- R3: A store of any value other than 0x59 to address 1 clears core_reset and nvm_en on the cycle after the store. A later load of address 1 then returns 0x00.
- R4: key_start begins a key window. The eight key_valid bytes that follow form a 64-bit word, least-significant byte first. If that word equals 0x1289AB45CDD888FF and core_reset is 1 when the eighth byte arrives, nvm_en is 1 from the cycle after the eighth byte.
- R5: If the eight-byte word differs from the key in any bit, nvm_en is 0 from the cycle after the eighth byte, even if it was 1 before.
- R6: A correct key delivered while core_reset is 0 leaves nvm_en at 0.
- R7: A window with fewer than eight bytes leaves nvm_en unchanged. Key bytes that arrive after the eighth byte, or before any key_start, are ignored.
- R8: Address 0 (status) reads bit 1 = nvm_en and bit 0 = core_reset, with all other bits 0. Stores to address 0 are ignored.
- R9: Address 2 (control) is an 8-bit read/write register. Addresses 3 to 15 read 0x00, and stores to them are ignored.
- R10: rd_valid is 1 exactly on the cycle after each ld_valid, with rd_data holding the addressed register. Otherwise rd_valid is 0 and rd_data is 0x00.
- R11: A key_start in the middle of a window discards the bytes received so far and starts a new eight-byte count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| st_valid | input | 1 | Store to a control/status register this cycle |
| st_addr | input | 4 | Store register address |
| st_data | input | 8 | Store data |
| ld_valid | input | 1 | Load from a control/status register this cycle |
| ld_addr | input | 4 | Load register address |
| key_start | input | 1 | Key instruction seen; opens a new key window |
| key_valid | input | 1 | A key byte is present |
| key_byte | input | 8 | Key byte, least significant first |
| rd_data | output | 8 | Load result |
| rd_valid | output | 1 | Load result valid |
| core_reset | output | 1 | Internal reset request |
| nvm_en | output | 1 | NVM access enabled |

## Verification
The reset register is swept over all 256 values, which separates the one hold signature from every near miss. The key path is tried with the correct key, with each of the 64 single-bit corruptions of it (one per key bit), and with the correct key sent while the hold is absent. Together these show that every key bit is compared and that the hold gate is applied. Truncated windows, surplus bytes and restarted windows confirm the byte counting. A full sweep of the control register and all unmapped addresses checks the register decode and the read strobe.

// File: rtl/kunl_pkg.sv
package kunl_pkg;
   localparam logic [63:0] KUNL_DEF_KEY = 64'h1289AB45CDD888FF;
   localparam logic [7:0]  KUNL_DEF_SIG = 8'h59;

   typedef enum logic [1:0] {
      SEL_STATUS,
      SEL_RESET,
      SEL_CTRL,
      SEL_NONE
   } kunl_sel_e;
endpackage

// File: rtl/kunl_key_shift.sv
module kunl_key_shift #(
   parameter int BYTE_W    = 8,
   parameter int KEY_BYTES = 8,
   parameter logic [BYTE_W*KEY_BYTES-1:0] KEY_VALUE = kunl_pkg::KUNL_DEF_KEY
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              key_start,
   input  logic              key_valid,
   input  logic [BYTE_W-1:0] key_byte,
   output logic              key_last,
   output logic              key_match
);
   localparam int KEY_W  = BYTE_W * KEY_BYTES;
   localparam int HOLD_W = KEY_W - BYTE_W;
   localparam int CNT_W  = $clog2(KEY_BYTES + 1);

   initial begin
      AST_KEY_BYTES_MIN: assert (KEY_BYTES >= 2) else $error("key needs two or more bytes"); // R4
      AST_BYTE_W_MIN: assert (BYTE_W >= 1) else $error("byte width must be positive"); // R4
   end

   logic [CNT_W-1:0]  cnt_q;
   logic [HOLD_W-1:0] hold_q;
   logic              accept;

   assign accept    = key_valid && !key_start && (cnt_q < CNT_W'(KEY_BYTES));
   assign key_last  = accept && (cnt_q == CNT_W'(KEY_BYTES - 1));
   assign key_match = ({key_byte, hold_q} == KEY_VALUE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= CNT_W'(KEY_BYTES);
         hold_q <= '0;
      end else if (key_start) begin
         cnt_q  <= '0;
         hold_q <= '0;
      end else if (accept) begin
         cnt_q  <= cnt_q + 1'b1;
         hold_q <= {key_byte, hold_q[HOLD_W-1:BYTE_W]};
      end
   end

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(KEY_BYTES)); // R7
   AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
      key_start |=> (cnt_q == '0)); // R11
   AST_DONE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == CNT_W'(KEY_BYTES) && !key_start) |=> (cnt_q == CNT_W'(KEY_BYTES))); // R7
endmodule

// File: rtl/kunl_csr_file.sv
module kunl_csr_file #(
   parameter int BYTE_W      = 8,
   parameter int ADDR_W      = 4,
   parameter int STATUS_ADDR = 0,
   parameter int RESET_ADDR  = 1,
   parameter int CTRL_ADDR   = 2,
   parameter int NVM_BIT     = 1,
   parameter logic [BYTE_W-1:0] HOLD_SIG = kunl_pkg::KUNL_DEF_SIG
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              st_valid,
   input  logic [ADDR_W-1:0] st_addr,
   input  logic [BYTE_W-1:0] st_data,
   input  logic              ld_valid,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic              key_last,
   input  logic              key_match,
   output logic [BYTE_W-1:0] rd_data,
   output logic              rd_valid,
   output logic              core_reset,
   output logic              nvm_en
);
   import kunl_pkg::*;

   initial begin
      AST_NVM_BIT_FITS: assert (NVM_BIT > 0 && NVM_BIT < BYTE_W) else $error("status bit position"); // R8
      AST_ADDR_FITS: assert (CTRL_ADDR < (1 << ADDR_W) && RESET_ADDR < (1 << ADDR_W)) else $error("address width"); // R9
   end

   function automatic kunl_sel_e decode(input logic [ADDR_W-1:0] a);
      if (a == ADDR_W'(STATUS_ADDR))     return SEL_STATUS;
      else if (a == ADDR_W'(RESET_ADDR)) return SEL_RESET;
      else if (a == ADDR_W'(CTRL_ADDR))  return SEL_CTRL;
      else                               return SEL_NONE;
   endfunction

   kunl_sel_e         st_sel, ld_sel;
   logic              rst_wr, release_wr;
   logic              hold_q, nvm_q;
   logic [BYTE_W-1:0] ctrl_q;
   logic [BYTE_W-1:0] status_byte, read_mux;

   assign st_sel     = decode(st_addr);
   assign ld_sel     = decode(ld_addr);
   assign rst_wr     = st_valid && (st_sel == SEL_RESET);
   assign release_wr = rst_wr && (st_data != HOLD_SIG);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= 1'b0;
         nvm_q  <= 1'b0;
         ctrl_q <= '0;
      end else begin
         if (rst_wr) hold_q <= (st_data == HOLD_SIG);
         if (st_valid && st_sel == SEL_CTRL) ctrl_q <= st_data;
         if (release_wr)    nvm_q <= 1'b0;
         else if (key_last) nvm_q <= key_match && hold_q;
      end
   end

   always_comb begin
      status_byte          = '0;
      status_byte[0]       = hold_q;
      status_byte[NVM_BIT] = nvm_q;
      unique case (ld_sel)
         SEL_STATUS: read_mux = status_byte;
         SEL_RESET:  read_mux = BYTE_W'(hold_q);
         SEL_CTRL:   read_mux = ctrl_q;
         default:    read_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= ld_valid;
         rd_data  <= ld_valid ? read_mux : '0;
      end
   end

   assign core_reset = hold_q;
   assign nvm_en     = nvm_q;

   AST_NVM_NEEDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      nvm_en |-> core_reset); // R6
   AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      release_wr |=> (!nvm_en && !core_reset)); // R3
   AST_GRANT_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(nvm_en) |-> $past(key_last && key_match)); // R4
   AST_MISMATCH_DENIES: assert property (@(posedge clk) disable iff (!rst_n)
      (key_last && !key_match) |=> !nvm_en); // R5
   AST_RD_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      ld_valid |=> rd_valid); // R10
   AST_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_valid |=> (!rd_valid && rd_data == '0)); // R10
endmodule

// File: rtl/key_unlock_csr.sv
module key_unlock_csr #(
   parameter int BYTE_W      = 8,
   parameter int ADDR_W      = 4,
   parameter int KEY_BYTES   = 8,
   parameter logic [BYTE_W*KEY_BYTES-1:0] KEY_VALUE = kunl_pkg::KUNL_DEF_KEY,
   parameter logic [BYTE_W-1:0] HOLD_SIG = kunl_pkg::KUNL_DEF_SIG,
   parameter int STATUS_ADDR = 0,
   parameter int RESET_ADDR  = 1,
   parameter int CTRL_ADDR   = 2,
   parameter int NVM_BIT     = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              st_valid,
   input  logic [ADDR_W-1:0] st_addr,
   input  logic [BYTE_W-1:0] st_data,
   input  logic              ld_valid,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic              key_start,
   input  logic              key_valid,
   input  logic [BYTE_W-1:0] key_byte,
   output logic [BYTE_W-1:0] rd_data,
   output logic              rd_valid,
   output logic              core_reset,
   output logic              nvm_en
);
   logic key_last, key_match;

   kunl_key_shift #(
      .BYTE_W(BYTE_W), .KEY_BYTES(KEY_BYTES), .KEY_VALUE(KEY_VALUE)
   ) u_key (
      .clk(clk), .rst_n(rst_n),
      .key_start(key_start), .key_valid(key_valid), .key_byte(key_byte),
      .key_last(key_last), .key_match(key_match)
   );

   kunl_csr_file #(
      .BYTE_W(BYTE_W), .ADDR_W(ADDR_W), .STATUS_ADDR(STATUS_ADDR),
      .RESET_ADDR(RESET_ADDR), .CTRL_ADDR(CTRL_ADDR), .NVM_BIT(NVM_BIT),
      .HOLD_SIG(HOLD_SIG)
   ) u_csr (
      .clk(clk), .rst_n(rst_n),
      .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data),
      .ld_valid(ld_valid), .ld_addr(ld_addr),
      .key_last(key_last), .key_match(key_match),
      .rd_data(rd_data), .rd_valid(rd_valid),
      .core_reset(core_reset), .nvm_en(nvm_en)
   );
endmodule

// File: tb/tb_key_unlock_csr.sv
module tb_key_unlock_csr;
   localparam logic [63:0] KEY = 64'h1289AB45CDD888FF;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       st_valid = 1'b0, ld_valid = 1'b0, key_start = 1'b0, key_valid = 1'b0;
   logic [3:0] st_addr = '0, ld_addr = '0;
   logic [7:0] st_data = '0, key_byte = '0;
   logic [7:0] rd_data;
   logic       rd_valid, core_reset, nvm_en;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   key_unlock_csr dut (
      .clk(clk), .rst_n(rst_n),
      .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data),
      .ld_valid(ld_valid), .ld_addr(ld_addr),
      .key_start(key_start), .key_valid(key_valid), .key_byte(key_byte),
      .rd_data(rd_data), .rd_valid(rd_valid),
      .core_reset(core_reset), .nvm_en(nvm_en)
   );

   always #2 clk = ~clk;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic store(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      st_valid = 1'b1; st_addr = a; st_data = d;
      @(negedge clk);
      st_valid = 1'b0;
   endtask

   task automatic load(input logic [3:0] a, output logic [7:0] d, output logic v);
      @(negedge clk);
      ld_valid = 1'b1; ld_addr = a;
      @(negedge clk);
      ld_valid = 1'b0;
      d = rd_data; v = rd_valid;
   endtask

   task automatic load_chk(input string req, input logic [3:0] a, input logic [7:0] exp);
      logic [7:0] d;
      logic v;
      load(a, d, v);
      chk(req, {56'd0, d}, {56'd0, exp});
      chk("R10 strobe", {63'd0, v}, 64'd1);
   endtask

   task automatic kstart();
      @(negedge clk);
      key_start = 1'b1;
      @(negedge clk);
      key_start = 1'b0;
   endtask

   task automatic kbytes(input logic [63:0] k, input int first, input int count);
      for (int i = first; i < first + count; i++) begin
         @(negedge clk);
         key_valid = 1'b1; key_byte = k[i*8 +: 8];
      end
      @(negedge clk);
      key_valid = 1'b0;
   endtask

   task automatic send_key(input logic [63:0] k);
      kstart();
      kbytes(k, 0, 8);
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      logic v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 core_reset", {63'd0, core_reset}, 64'd0);
      chk("R1 nvm_en", {63'd0, nvm_en}, 64'd0);
      chk("R10 idle rd_valid", {63'd0, rd_valid}, 64'd0);
      load_chk("R1 status", 4'd0, 8'h00);
      load_chk("R1 reset reg", 4'd1, 8'h00);
      load_chk("R1 control", 4'd2, 8'h00);
      @(negedge clk);
      chk("R10 rd_valid drops", {63'd0, rd_valid}, 64'd0);
      chk("R10 rd_data zero", {56'd0, rd_data}, 64'd0);

      // R9 control register sweep
      for (int x = 0; x < 256; x++) begin
         store(4'd2, 8'(x));
         load_chk("R9 control", 4'd2, 8'(x));
      end
      // R9 unmapped addresses
      for (int a = 3; a < 16; a++) begin
         store(4'(a), 8'hFF);
         load_chk("R9 unmapped", 4'(a), 8'h00);
      end
      load_chk("R9 control untouched", 4'd2, 8'hFF);
      // R8 status store ignored
      store(4'd0, 8'hFF);
      load_chk("R8 status ignores store", 4'd0, 8'h00);

      // R2 R3 reset register sweep
      for (int x = 0; x < 256; x++) begin
         store(4'd1, 8'(x));
         chk(x == 8'h59 ? "R2 hold" : "R3 release", {63'd0, core_reset}, {63'd0, (x == 8'h59)});
         load_chk("R2 reset readback", 4'd1, (x == 8'h59) ? 8'h01 : 8'h00);
      end
      store(4'd1, 8'h00);

      // R7 stray bytes before key_start
      kbytes(KEY, 0, 8);
      chk("R7 no window", {63'd0, nvm_en}, 64'd0);

      // R6 correct key without hold
      send_key(KEY);
      chk("R6 no hold", {63'd0, nvm_en}, 64'd0);

      store(4'd1, 8'h59);
      load_chk("R8 status hold only", 4'd0, 8'h01);
      // R5 single-bit corruptions
      for (int b = 0; b < 64; b++) begin
         send_key(KEY ^ (64'd1 << b));
         chk("R5 bit flip", {63'd0, nvm_en}, 64'd0);
      end
      // R7 short window
      kstart();
      kbytes(KEY, 0, 7);
      chk("R7 seven bytes", {63'd0, nvm_en}, 64'd0);

      // R4 grant
      send_key(KEY);
      chk("R4 grant", {63'd0, nvm_en}, 64'd1);
      load_chk("R8 status granted", 4'd0, 8'h03);
      // R7 surplus bytes ignored
      kbytes(~KEY, 0, 8);
      chk("R7 surplus", {63'd0, nvm_en}, 64'd1);
      // R5 mismatch revokes
      send_key(~KEY);
      chk("R5 revoke", {63'd0, nvm_en}, 64'd0);
      // R11 restart mid window
      kstart();
      kbytes(~KEY, 0, 3);
      send_key(KEY);
      chk("R11 restart", {63'd0, nvm_en}, 64'd1);
      // R3 release clears access
      store(4'd1, 8'h58);
      chk("R3 nvm cleared", {63'd0, nvm_en}, 64'd0);
      chk("R3 reset released", {63'd0, core_reset}, 64'd0);
      load_chk("R3 status cleared", 4'd0, 8'h00);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule